// File: doc/BRIEF.md
# CAN Fault Confinement with Error and Status Interrupts

This block keeps the transmit and receive error counters of a CAN node and derives three fault levels from them: a warning level, an error-passive level and bus-off. A protocol engine reports each finished frame through single-cycle event pulses: transmit good, transmit failed, receive good and receive failed. With each frame it also supplies a three-bit last-error code. The block folds these events into a status word. Software reads that word, and the read clears the sticky flags in it.

A single level interrupt line is raised when an enabled flag changes from 0 to 1. Error flags and status flags have separate enables. The line stays high until software reads the status word. While the node is in bus-off, it ignores all frame events. If automatic recovery is enabled, the node leaves bus-off after it has counted enough recessive-sequence pulses, and both counters are zeroed at that point.

Top module: `can_fc_top`

## Requirements
- R1: After reset, both counters are 0, the three state outputs are 0, the status word is 0 and the interrupt is low.
- R2: A failed transmission adds 8 to the transmit counter and a failed reception adds 1 to the receive counter. Both counters saturate at 255. A failure wins over a success pulse on the same side in the same cycle.
- R3: A successful transmission or reception lowers its own counter by 1. A counter at 0 stays at 0.
- R4: `warnSt` is high exactly while either counter is above 96.
- R5: `passSt` is high exactly while either counter is above 127. `warnSt` stays high alongside it.
- R6: Bus-off is entered in the cycle after a failed transmission that brings the transmit counter to 255. While in bus-off, frame events change neither the counters nor any status flag.
- R7: Status word layout: bits 2:0 hold the last error code, loaded on every accepted frame event. Bit 3 is transmit-good, bit 4 is receive-good, bit 5 is the warning flag, bit 6 is error-passive (live), bit 7 is bus-off (live) and bit 8 is parity error (set by `parErr`).
- R8: A status read clears bits 2:0, 3, 4, 5 and 8. A set condition in the same cycle wins over the clear. Bits 6 and 7 follow the state and are not affected by a read.
- R9: The interrupt rises when bus-off, warning or parity goes 0→1 and `errIe` is set. It also rises when transmit-good, receive-good or a nonzero error code goes 0→1 and `stsIe` is set. Error-passive never raises it, and no 1→0 change raises it.
- R10: The interrupt is a level that holds until a status read. If a read coincides with a new enabled rise, the interrupt stays high.
- R11: In bus-off with `autoRecov` high, the 128th `recessSeq` pulse returns the node to error-active and zeroes both counters. Pulses seen while `autoRecov` is low are not counted.
- R12: The warning flag is set only on an accepted frame event, and only when the updated counters are above the warning level. After a read, it stays clear until the next such event, even though the counter is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txOk | input | 1 | Transmission completed pulse |
| txErr | input | 1 | Transmission failed pulse |
| rxOk | input | 1 | Reception completed pulse |
| rxErr | input | 1 | Reception failed pulse |
| lecIn | input | 3 | Last error code for the current frame event |
| parErr | input | 1 | Parity error pulse |
| errIe | input | 1 | Enable for error-flag interrupts |
| stsIe | input | 1 | Enable for status-flag interrupts |
| autoRecov | input | 1 | Enable for automatic bus-off recovery |
| statusRd | input | 1 | Status word read strobe |
| recessSeq | input | 1 | Recessive sequence detected pulse |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| warnSt | output | 1 | Warning level reached |
| passSt | output | 1 | Error-passive level reached |
| busOff | output | 1 | Node is in bus-off |
| status | output | 9 | Status word |
| irq | output | 1 | Interrupt level |

## Verification
Two things can fall in the same cycle: a status read, and a frame event that sets again a flag the read is clearing. The bench provokes this directly with a read issued together with a failed transmission while the warning level holds. It also provokes it at random, with reads on about one cycle in ten across event-heavy phases. The result is judged against a bench model in which the set wins and the interrupt is raised again. The model also covers a recovery pulse that lands while frame events are still arriving in bus-off.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef struct packed {
    logic txInc;
    logic txGood;
    logic rxInc;
    logic rxGood;
    logic frameEvt;
    logic recovDone;
    logic rdClr;
  } fcStrobes_t;

  typedef enum logic {ST_ACTIVE = 1'b0, ST_BUSOFF = 1'b1} fcState_e;
endpackage

// File: rtl/can_fc_ctrl.sv
module can_fc_ctrl
  import can_fc_pkg::*;
#(
  parameter int RECOV_PULSES = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txOk,
  input  logic       txErr,
  input  logic       rxOk,
  input  logic       rxErr,
  input  logic       statusRd,
  input  logic       recessSeq,
  input  logic       autoRecov,
  input  logic       tecHitMax,
  output fcStrobes_t strb,
  output logic       busOff
);
  localparam int RC_W = (RECOV_PULSES > 1) ? $clog2(RECOV_PULSES) : 1;
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RECOV_PULSES - 1);

  fcState_e        state, stateNext;
  logic [RC_W-1:0] rcCnt;
  logic            onBus;
  logic            countPulse;

  assign onBus      = (state == ST_ACTIVE);
  assign countPulse = (state == ST_BUSOFF) && autoRecov && recessSeq;

  always_comb begin
    strb.txInc     = onBus && txErr;
    strb.txGood    = onBus && txOk;
    strb.rxInc     = onBus && rxErr;
    strb.rxGood    = onBus && rxOk;
    strb.frameEvt  = onBus && (txOk || txErr || rxOk || rxErr);
    strb.recovDone = countPulse && (rcCnt == RC_LAST);
    strb.rdClr     = statusRd;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_ACTIVE: if (tecHitMax) stateNext = ST_BUSOFF;
      ST_BUSOFF: if (strb.recovDone) stateNext = ST_ACTIVE;
      default:   stateNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_ACTIVE;
      rcCnt <= '0;
    end else begin
      state <= stateNext;
      if (state != ST_BUSOFF || strb.recovDone) rcCnt <= '0;
      else if (countPulse) rcCnt <= rcCnt + 1'b1;
    end
  end

  assign busOff = (state == ST_BUSOFF);
endmodule

// File: rtl/can_fc_dp.sv
module can_fc_dp
  import can_fc_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LEC_W    = 3,
  parameter int TX_STEP  = 8,
  parameter int RX_STEP  = 1,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 127
) (
  input  logic               clk,
  input  logic               rstN,
  input  fcStrobes_t         strb,
  input  logic               busOff,
  input  logic [LEC_W-1:0]   lecIn,
  input  logic               parErr,
  input  logic               errIe,
  input  logic               stsIe,
  output logic               tecHitMax,
  output logic [CNT_W-1:0]   tec,
  output logic [CNT_W-1:0]   rec,
  output logic               warnSt,
  output logic               passSt,
  output logic [LEC_W+5:0]   status,
  output logic               irq
);
  localparam logic [CNT_W-1:0] MAX_V  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LVL);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LVL);
  localparam logic [CNT_W:0]   TXS_V  = (CNT_W+1)'(TX_STEP);
  localparam logic [CNT_W:0]   RXS_V  = (CNT_W+1)'(RX_STEP);

  function automatic logic [CNT_W-1:0] satAdd(input logic [CNT_W-1:0] v,
                                              input logic [CNT_W:0] step);
    logic [CNT_W:0] s;
    s = {1'b0, v} + step;
    return (s > {1'b0, MAX_V}) ? MAX_V : s[CNT_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] nextCnt(input logic [CNT_W-1:0] v,
                                               input logic inc, input logic good,
                                               input logic clr, input logic [CNT_W:0] step);
    if (clr) return '0;
    if (inc) return satAdd(v, step);
    if (good && v != '0) return v - 1'b1;
    return v;
  endfunction

  logic [CNT_W-1:0] tecNext, recNext;
  logic             warnF, txF, rxF, parF;
  logic [LEC_W-1:0] lec;
  logic             warnN, txN, rxN, parN;
  logic [LEC_W-1:0] lecN, lecBase;
  logic             warnRise, txRise, rxRise, parRise, lecRise, irqN;

  assign tecNext   = nextCnt(tec, strb.txInc, strb.txGood, strb.recovDone, TXS_V);
  assign recNext   = nextCnt(rec, strb.rxInc, strb.rxGood, strb.recovDone, RXS_V);
  assign tecHitMax = strb.txInc && (tecNext == MAX_V);

  always_comb begin
    warnN   = (strb.frameEvt && (tecNext > WARN_V || recNext > WARN_V)) ||
              (warnF && !strb.rdClr);
    txN     = strb.txGood || (txF && !strb.rdClr);
    rxN     = strb.rxGood || (rxF && !strb.rdClr);
    parN    = parErr || (parF && !strb.rdClr);
    lecBase = strb.rdClr ? '0 : lec;
    lecN    = strb.frameEvt ? lecIn : lecBase;
    // a rise is measured against the flag after this cycle's read clear
    warnRise = warnN && !(warnF && !strb.rdClr);
    txRise   = txN && !(txF && !strb.rdClr);
    rxRise   = rxN && !(rxF && !strb.rdClr);
    parRise  = parN && !(parF && !strb.rdClr);
    lecRise  = (lecN != '0) && (lecBase == '0);
    irqN = (errIe && (tecHitMax || warnRise || parRise)) ||
           (stsIe && (txRise || rxRise || lecRise)) ||
           (irq && !strb.rdClr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tec <= '0; rec <= '0;
      warnF <= 1'b0; txF <= 1'b0; rxF <= 1'b0; parF <= 1'b0;
      lec <= '0; irq <= 1'b0;
    end else begin
      tec <= tecNext; rec <= recNext;
      warnF <= warnN; txF <= txN; rxF <= rxN; parF <= parN;
      lec <= lecN; irq <= irqN;
    end
  end

  assign warnSt = (tec > WARN_V) || (rec > WARN_V);
  assign passSt = (tec > PASS_V) || (rec > PASS_V);
  assign status = {parF, busOff, passSt, warnF, rxF, txF, lec};
endmodule

// File: rtl/can_fc_top.sv
module can_fc_top
  import can_fc_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int LEC_W        = 3,
  parameter int TX_STEP      = 8,
  parameter int RX_STEP      = 1,
  parameter int WARN_LVL     = 96,
  parameter int PASS_LVL     = 127,
  parameter int RECOV_PULSES = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txOk,
  input  logic             txErr,
  input  logic             rxOk,
  input  logic             rxErr,
  input  logic [LEC_W-1:0] lecIn,
  input  logic             parErr,
  input  logic             errIe,
  input  logic             stsIe,
  input  logic             autoRecov,
  input  logic             statusRd,
  input  logic             recessSeq,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic             warnSt,
  output logic             passSt,
  output logic             busOff,
  output logic [LEC_W+5:0] status,
  output logic             irq
);
  fcStrobes_t strb;
  logic       tecHitMax;

  can_fc_ctrl #(.RECOV_PULSES(RECOV_PULSES)) i_ctrl (
    .clk(clk), .rstN(rstN), .txOk(txOk), .txErr(txErr), .rxOk(rxOk), .rxErr(rxErr),
    .statusRd(statusRd), .recessSeq(recessSeq), .autoRecov(autoRecov),
    .tecHitMax(tecHitMax), .strb(strb), .busOff(busOff)
  );

  can_fc_dp #(.CNT_W(CNT_W), .LEC_W(LEC_W), .TX_STEP(TX_STEP), .RX_STEP(RX_STEP),
              .WARN_LVL(WARN_LVL), .PASS_LVL(PASS_LVL)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busOff(busOff), .lecIn(lecIn),
    .parErr(parErr), .errIe(errIe), .stsIe(stsIe), .tecHitMax(tecHitMax),
    .tec(tec), .rec(rec), .warnSt(warnSt), .passSt(passSt), .status(status), .irq(irq)
  );
endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             txOk,
  input logic             txErr,
  input logic             statusRd,
  input logic             autoRecov,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic             warnSt,
  input logic             passSt,
  input logic             busOff,
  input logic             irq
);
  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] NEAR  = MAX_V - CNT_W'(8);

  // R2: a failed transmission below the ceiling adds exactly eight
  p_tx_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && txErr && tec < NEAR) |=> (tec == $past(tec) + CNT_W'(8)));

  // R3: a counter at zero does not go below zero on a success
  p_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && txOk && !txErr && tec == '0) |=> (tec == '0));

  // R5: passive implies warning
  p_pass_warn_r5: assert property (@(posedge clk) disable iff (!rstN)
    passSt |-> warnSt);

  // R6: bus-off is only entered with the counter at its ceiling
  p_boff_max_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOff) |-> (tec == MAX_V));

  // R6: without recovery, bus-off freezes both counters
  p_boff_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && !autoRecov) |=> ($stable(tec) && $stable(rec)));

  // R10: the interrupt only drops after a read
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !statusRd) |=> irq);

  // R11: leaving bus-off zeroes both counters
  p_recov_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOff) |-> (tec == '0 && rec == '0));
endmodule

bind can_fc_top can_fc_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .txOk(txOk), .txErr(txErr), .statusRd(statusRd),
  .autoRecov(autoRecov), .tec(tec), .rec(rec), .warnSt(warnSt), .passSt(passSt),
  .busOff(busOff), .irq(irq)
);

// File: tb/test_can_fc_top.sv
module test_can_fc_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txOk = 0, txErr = 0, rxOk = 0, rxErr = 0, parErr = 0;
  logic errIe = 0, stsIe = 0, autoRecov = 0, statusRd = 0, recessSeq = 0;
  logic [2:0] lecIn = '0;
  logic [7:0] tec, rec;
  logic       warnSt, passSt, busOff, irq;
  logic [8:0] status;

  int total = 0;
  int bad = 0;

  // bench model, built from the requirements
  int mTec, mRec, mRc;
  bit mOff, mWarnF, mTxF, mRxF, mParF, mIrq;
  bit [2:0] mLec;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fc_top i_can_fc_top (
    .clk(clk), .rstN(rstN), .txOk(txOk), .txErr(txErr), .rxOk(rxOk), .rxErr(rxErr),
    .lecIn(lecIn), .parErr(parErr), .errIe(errIe), .stsIe(stsIe), .autoRecov(autoRecov),
    .statusRd(statusRd), .recessSeq(recessSeq), .tec(tec), .rec(rec), .warnSt(warnSt),
    .passSt(passSt), .busOff(busOff), .status(status), .irq(irq)
  );

  function automatic int addSat(int v, int s);
    return (v + s > 255) ? 255 : v + s;
  endfunction

  function automatic bit [8:0] expStatus();
    bit pass;
    pass = (mTec > 127) || (mRec > 127);
    return {mParF, mOff, pass, mWarnF, mRxF, mTxF, mLec};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit gate, ev, done, hit, wc, bW, bT, bR, bP, wN, tN, rN, pN, irqN;
    int nTec, nRec;
    bit [2:0] lBase, lN;
    gate = !mOff;
    ev   = gate && (txOk || txErr || rxOk || rxErr);
    done = mOff && autoRecov && recessSeq && (mRc == 127);
    nTec = mTec; nRec = mRec;
    if (done) begin nTec = 0; nRec = 0; end
    else begin
      if (gate && txErr) nTec = addSat(mTec, 8);
      else if (gate && txOk && mTec > 0) nTec = mTec - 1;
      if (gate && rxErr) nRec = addSat(mRec, 1);
      else if (gate && rxOk && mRec > 0) nRec = mRec - 1;
    end
    hit = gate && txErr && (nTec == 255);
    wc  = (nTec > 96) || (nRec > 96);
    bW = mWarnF && !statusRd; bT = mTxF && !statusRd;
    bR = mRxF && !statusRd;   bP = mParF && !statusRd;
    wN = (ev && wc) || bW;
    tN = (gate && txOk) || bT;
    rN = (gate && rxOk) || bR;
    pN = parErr || bP;
    lBase = statusRd ? 3'd0 : mLec;
    lN = ev ? lecIn : lBase;
    irqN = (errIe && (hit || (wN && !bW) || (pN && !bP))) ||
           (stsIe && ((tN && !bT) || (rN && !bR) || (lN != 0 && lBase == 0))) ||
           (mIrq && !statusRd);
    if (!mOff) mRc = 0;
    else if (autoRecov && recessSeq) mRc = done ? 0 : mRc + 1;
    mOff = mOff ? !done : hit;
    mTec = nTec; mRec = nRec;
    mWarnF = wN; mTxF = tN; mRxF = rN; mParF = pN; mLec = lN; mIrq = irqN;
  endtask

  task automatic stepAndCompare(input string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    txOk = 0; txErr = 0; rxOk = 0; rxErr = 0; parErr = 0;
    statusRd = 0; recessSeq = 0; lecIn = '0;
    check({tag, " tec"}, tec, mTec);
    check({tag, " rec"}, rec, mRec);
    check({tag, " warnSt"}, warnSt, (mTec > 96) || (mRec > 96));
    check({tag, " passSt"}, passSt, (mTec > 127) || (mRec > 127));
    check({tag, " busOff"}, busOff, mOff);
    check({tag, " status"}, status, expStatus());
    check({tag, " irq"}, irq, mIrq);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mTec = 0; mRec = 0; mRc = 0; mOff = 0; mWarnF = 0; mTxF = 0; mRxF = 0;
    mParF = 0; mIrq = 0; mLec = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 tec", tec, 0); check("R1 rec", rec, 0);
    check("R1 status", status, 0); check("R1 irq", irq, 0);
    check("R1 states", {warnSt, passSt, busOff}, 0);

    // R3 success at zero leaves zero; R7 txOk flag with status irq
    stsIe = 1; txOk = 1; stepAndCompare("R3");
    check("R3 floor", tec, 0);
    check("R7 txOk bit", status[3], 1);
    check("R9 status rise irq", irq, 1);
    statusRd = 1; stepAndCompare("R8");
    check("R8 cleared", status, 0);
    check("R10 read drops irq", irq, 0);
    stsIe = 0;

    // R2/R4 thirteen failed transmissions reach warning
    errIe = 1;
    for (int i = 0; i < 13; i++) begin txErr = 1; lecIn = 3'd3; stepAndCompare("R2"); end
    check("R2 tec", tec, 104);
    check("R4 warn", warnSt, 1);
    check("R7 lec", status[2:0], 3);
    check("R9 warn irq", irq, 1);
    statusRd = 1; stepAndCompare("R8");
    check("R8 warn bit clear", status[5], 0);
    check("R8 irq clear", irq, 0);
    // R12 no retrigger without a frame event
    repeat (5) stepAndCompare("R12");
    check("R12 no retrigger", {status[5], irq}, 0);
    rxOk = 1; stepAndCompare("R12");
    check("R12 set on event", {status[5], irq}, 2'b11);
    // R10 read and new warning rise in the same cycle
    statusRd = 1; txErr = 1; stepAndCompare("R10");
    check("R10 irq kept", irq, 1);
    check("R5 tec", tec, 112);
    for (int i = 0; i < 2; i++) begin txErr = 1; stepAndCompare("R5"); end
    check("R5 passive+warn", {passSt, warnSt}, 2'b11);
    check("R2 tec 128", tec, 128);

    // R6 climb to bus-off
    for (int i = 0; i < 16; i++) begin txErr = 1; stepAndCompare("R6"); end
    check("R6 busOff", busOff, 1);
    check("R6 tec max", tec, 255);
    statusRd = 1; stepAndCompare("R8");
    check("R8 live bits kept", status[7:6], 2'b11);
    txOk = 1; rxErr = 1; lecIn = 3'd5; stepAndCompare("R6");
    check("R6 ignored", {tec, rec, status}, {8'd255, 8'd0, 9'b011000000});

    // R11 pulses without enable are not counted
    for (int i = 0; i < 130; i++) begin recessSeq = 1; stepAndCompare("R11"); end
    check("R11 no auto", busOff, 1);
    autoRecov = 1;
    for (int i = 0; i < 127; i++) begin recessSeq = 1; stepAndCompare("R11"); end
    check("R11 still off", busOff, 1);
    recessSeq = 1; stepAndCompare("R11");
    check("R11 recovered", {busOff, tec, rec}, 17'd0);
    check("R9 no irq on fall", irq, 0);
    parErr = 1; stepAndCompare("R9");
    check("R9 parity irq", {status[8], irq}, 2'b11);
    rxErr = 1; stepAndCompare("R2");
    check("R2 rec", rec, 1);

    // constrained random phases
    begin
      int seed = 7;
      void'($urandom(seed));
    end
    for (int i = 0; i < 6000; i++) begin
      int ph = (i / 400) % 4;
      if (i % 64 == 0) begin
        errIe = 1'($urandom_range(0, 1));
        stsIe = 1'($urandom_range(0, 1));
        autoRecov = ($urandom_range(0, 3) != 0);
      end
      case (ph)
        0: begin txOk = 1'($urandom); txErr = 1'($urandom); rxOk = 1'($urandom); rxErr = 1'($urandom); end
        1: begin txErr = ($urandom_range(0, 9) < 7); rxErr = ($urandom_range(0, 9) < 6); end
        2: begin txOk = ($urandom_range(0, 9) < 7); rxOk = ($urandom_range(0, 9) < 7); end
        default: begin recessSeq = 1'($urandom); txErr = ($urandom_range(0, 9) < 3); end
      endcase
      lecIn = 3'($urandom_range(0, 7));
      parErr = ($urandom_range(0, 49) == 0);
      statusRd = ($urandom_range(0, 9) == 0);
      stepAndCompare("R7 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule